// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 64-word by 36-bit first-in first-out buffer that joins two clock domains. Words enter through a write port on one clock and leave through a read port on a second, unrelated clock. Each port decodes four control lines to decide whether a buffer access happens on its clock edge. The same lines decide whether that port's data bus would be driven. The tri-state bus is shown as a separate output-enable signal.

The buffer gives four active-low status outputs. Two are "not full" and "almost full", made in the write domain. The other two are "not empty" and "almost empty", made in the read domain. The threshold for both almost flags comes from a two-bit select input and is captured once, when reset is released. Pointers cross between the domains as Gray codes through two-flop synchronisers. The active-low reset input may change at any time; each domain has its own synchroniser for it.

Top module: `dcfifo_flags`

## Requirements
- R1: While `rst_n` has been low for at least four edges of each clock, the outputs are `full_n`=0, `empty_n`=0, `aempty_n`=0 and `afull_n`=1. After release, the buffer holds no words, whatever it held before: `empty_n`=0, `aempty_n`=0, `afull_n`=1 and `full_n`=1.
- R2: When `rst_n` rises between two `wclk` edges, `full_n` is still 0 after the first following `wclk` rising edge and is 1 after the second.
- R3: The threshold T is captured from `ofs_sel` when reset is released: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 12 and 2'b11 gives 16.
- R4: A word is stored on a `wclk` rising edge only when {`a_cs_n`,`a_wr_rd`,`a_en`,`a_mb`} = 4'b0110 and `full_n` is 1. Every other combination stores nothing.
- R5: A word is read on an `rclk` rising edge only when {`b_cs_n`,`b_wr_rd`,`b_en`,`b_mb`} = 4'b0010 and `empty_n` is 1. `b_dout` takes the oldest word on that edge and holds its value on every other edge.
- R6: `a_oe` is 1 exactly when `a_cs_n`=0 and `a_wr_rd`=0. `b_oe` is 1 exactly when `b_cs_n`=0 and `b_wr_rd`=0.
- R7: Once the flags have settled, `empty_n`=0 exactly when no words are stored, and `full_n`=0 exactly when 64 words are stored.
- R8: Once the flags have settled, with N words stored, `aempty_n`=0 exactly when N <= T, and `afull_n`=0 exactly when 64-N <= T.
- R9: A write attempted while `full_n`=0 leaves the contents and the write pointer unchanged. A read attempted while `empty_n`=0 leaves `b_dout` and the read pointer unchanged.
- R10: When writes and reads run at the same time on unrelated clocks, every word is read once, in the order it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| rclk | input | 1 | Read-port clock |
| rst_n | input | 1 | Active-low reset, asynchronous to both clocks |
| ofs_sel | input | 2 | Threshold select, captured at reset release |
| a_cs_n | input | 1 | Write-port chip select, active low |
| a_wr_rd | input | 1 | Write-port direction, 1 = write |
| a_en | input | 1 | Write-port enable |
| a_mb | input | 1 | Write-port mailbox select; 1 blocks a buffer access |
| a_din | input | 36 | Write data |
| a_oe | output | 1 | Write-port bus drive enable |
| b_cs_n | input | 1 | Read-port chip select, active low |
| b_wr_rd | input | 1 | Read-port direction, 0 = read |
| b_en | input | 1 | Read-port enable |
| b_mb | input | 1 | Read-port mailbox select; 1 blocks a buffer access |
| b_dout | output | 36 | Read data register |
| b_oe | output | 1 | Read-port bus drive enable |
| full_n | output | 1 | Not-full flag, write domain |
| afull_n | output | 1 | Not-almost-full flag, write domain |
| empty_n | output | 1 | Not-empty flag, read domain |
| aempty_n | output | 1 | Not-almost-empty flag, read domain |

## Verification
A write on `wclk` and a read on `rclk` can land in the same instant. Each domain then changes its own pointer while the other domain's copy of that pointer is still in flight. The bench runs a writer process and a reader process at once. The writer runs on a 4 ns clock and the reader on a 6 ns clock, so the buffer fills and the write port is held off by `full_n` many times. Each process drives its port only when its own flag allows, and every word read is compared with a computed sequence, so a lost, repeated or reordered word shows up as a data mismatch.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Four control lines of one port, most significant first.
  typedef struct packed {
    logic cs_n;
    logic wr_rd;
    logic en;
    logic mb;
  } port_ctl_t;

  // A buffer access is requested when the port is selected, the direction
  // matches, the port is enabled and the mailbox path is not chosen.
  function automatic logic fifo_go(port_ctl_t c, logic want_wr);
    return !c.cs_n && (c.wr_rd == want_wr) && c.en && !c.mb;
  endfunction

  // The port's bus is driven when it is selected and pointed outward.
  function automatic logic bus_drive(port_ctl_t c);
    return !c.cs_n && !c.wr_rd;
  endfunction

endpackage

// File: rtl/dcf_rst_cap.sv
// Two-flop reset synchroniser for one domain. While reset is held, the
// threshold is reloaded from the select pins; it freezes on release.
module dcf_rst_cap #(
  parameter int AW   = 6,
  parameter int STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n_async,
  input  logic [1:0]  sel,
  output logic        rst,
  output logic [AW:0] ofs
);

  logic [1:0] sh;

  always_ff @(posedge clk) begin
    sh <= {sh[0], rst_n_async};
    if (!sh[1]) ofs <= (AW+1)'((32'(sel) + 1) * STEP);
  end

  assign rst = ~sh[1];

endmodule

// File: rtl/dcf_ram.sv
// Simple dual-port storage: one write clock, one registered read clock.
module dcf_ram #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk)
    if (we) mem[waddr] <= wdata;

  always_ff @(posedge rclk)
    if (re) rdata <= mem[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
// Write-domain pointer, read-pointer synchroniser, full and almost-full.
module dcf_wr_side #(
  parameter int AW   = 6,
  parameter int STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n_async,
  input  logic [1:0]  sel,
  input  logic        wr_req,
  input  logic [AW:0] rgray_async,
  output logic [AW:0] wbin,
  output logic [AW:0] wgray,
  output logic        full_n,
  output logic        afull_n,
  output logic        wr_fire,
  output logic        w_rst
);

  localparam int DEPTH = 1 << AW;

  logic [AW:0]   ofs;
  logic [AW:0]   rg_s1, rg_s2, rbin_s;
  logic [AW:0]   wbin_nx, wgray_nx, used;
  logic [AW+1:0] free;
  logic          nfull_q;

  dcf_rst_cap #(.AW(AW), .STEP(STEP)) u_rc (
    .clk(clk), .rst_n_async(rst_n_async), .sel(sel), .rst(w_rst), .ofs(ofs)
  );

  always_comb
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rg_s2 >> i);

  assign wr_fire  = wr_req & full_n;
  assign wbin_nx  = wbin + {{AW{1'b0}}, wr_fire};
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign used     = wbin_nx - rbin_s;
  assign free     = (AW+2)'(DEPTH) - {1'b0, used};

  always_ff @(posedge clk) begin
    if (w_rst) begin
      wbin    <= '0;
      wgray   <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
      nfull_q <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wgray_nx;
      rg_s1   <= rgray_async;
      rg_s2   <= rg_s1;
      nfull_q <= wgray_nx != {~rg_s2[AW:AW-1], rg_s2[AW-2:0]};
      afull_n <= free > {1'b0, ofs};
    end
  end

  // Held low through reset; rises with the second edge after release.
  assign full_n = ~w_rst & nfull_q;

endmodule

// File: rtl/dcf_rd_side.sv
// Read-domain pointer, write-pointer synchroniser, empty and almost-empty.
module dcf_rd_side #(
  parameter int AW   = 6,
  parameter int STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n_async,
  input  logic [1:0]  sel,
  input  logic        rd_req,
  input  logic [AW:0] wgray_async,
  output logic [AW:0] rbin,
  output logic [AW:0] rgray,
  output logic        empty_n,
  output logic        aempty_n,
  output logic        rd_fire,
  output logic        r_rst
);

  logic [AW:0] ofs;
  logic [AW:0] wg_s1, wg_s2, wbin_s;
  logic [AW:0] rbin_nx, rgray_nx, used;

  dcf_rst_cap #(.AW(AW), .STEP(STEP)) u_rc (
    .clk(clk), .rst_n_async(rst_n_async), .sel(sel), .rst(r_rst), .ofs(ofs)
  );

  always_comb
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wg_s2 >> i);

  assign rd_fire  = rd_req & empty_n;
  assign rbin_nx  = rbin + {{AW{1'b0}}, rd_fire};
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign used     = wbin_s - rbin_nx;

  always_ff @(posedge clk) begin
    if (r_rst) begin
      rbin     <= '0;
      rgray    <= '0;
      wg_s1    <= '0;
      wg_s2    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      wg_s1    <= wgray_async;
      wg_s2    <= wg_s1;
      empty_n  <= rgray_nx != wg_s2;
      aempty_n <= used > ofs;
    end
  end

endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
  import dcf_pkg::*;
#(
  parameter int DW   = 36,
  parameter int AW   = 6,
  parameter int STEP = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [1:0]    ofs_sel,
  input  logic          a_cs_n,
  input  logic          a_wr_rd,
  input  logic          a_en,
  input  logic          a_mb,
  input  logic [DW-1:0] a_din,
  output logic          a_oe,
  input  logic          b_cs_n,
  input  logic          b_wr_rd,
  input  logic          b_en,
  input  logic          b_mb,
  output logic [DW-1:0] b_dout,
  output logic          b_oe,
  output logic          full_n,
  output logic          afull_n,
  output logic          empty_n,
  output logic          aempty_n
);

  port_ctl_t   a_ctl, b_ctl;
  logic        wr_req, rd_req, wr_fire, rd_fire, w_rst, r_rst;
  logic [AW:0] wbin, wgray, rbin, rgray;

  assign a_ctl  = {a_cs_n, a_wr_rd, a_en, a_mb};
  assign b_ctl  = {b_cs_n, b_wr_rd, b_en, b_mb};
  assign wr_req = fifo_go(a_ctl, 1'b1);
  assign rd_req = fifo_go(b_ctl, 1'b0);
  assign a_oe   = bus_drive(a_ctl);
  assign b_oe   = bus_drive(b_ctl);

  dcf_wr_side #(.AW(AW), .STEP(STEP)) u_wr (
    .clk(wclk), .rst_n_async(rst_n), .sel(ofs_sel), .wr_req(wr_req),
    .rgray_async(rgray), .wbin(wbin), .wgray(wgray), .full_n(full_n),
    .afull_n(afull_n), .wr_fire(wr_fire), .w_rst(w_rst)
  );

  dcf_rd_side #(.AW(AW), .STEP(STEP)) u_rd (
    .clk(rclk), .rst_n_async(rst_n), .sel(ofs_sel), .rd_req(rd_req),
    .wgray_async(wgray), .rbin(rbin), .rgray(rgray), .empty_n(empty_n),
    .aempty_n(aempty_n), .rd_fire(rd_fire), .r_rst(r_rst)
  );

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(a_din),
    .rclk(rclk), .re(rd_fire), .raddr(rbin[AW-1:0]), .rdata(b_dout)
  );

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input logic          wclk,
  input logic          rclk,
  input logic          w_rst,
  input logic          r_rst,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic          wr_req,
  input logic          rd_req,
  input logic          rd_fire,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [DW-1:0] b_dout
);

  // R1: write-domain flags sit at their reset levels while reset is held
  p_reset_wflags_r1: assert property (@(posedge wclk)
    (w_rst && $past(w_rst)) |-> (!full_n && afull_n));

  // R1: read-domain flags sit at their reset levels while reset is held
  p_reset_rflags_r1: assert property (@(posedge rclk)
    (r_rst && $past(r_rst)) |-> (!empty_n && !aempty_n));

  // R2: not-full is already up once the domain has left reset
  p_full_up_r2: assert property (@(posedge wclk)
    $fell(w_rst) |-> full_n);

  // R9: a write blocked by the full flag does not move the write pointer
  p_no_overflow_r9: assert property (@(posedge wclk) disable iff (w_rst)
    (wr_req && !full_n) |=> $stable(wbin));

  // R9: a read blocked by the empty flag does not move the read pointer
  p_no_underflow_r9: assert property (@(posedge rclk) disable iff (r_rst)
    (rd_req && !empty_n) |=> $stable(rbin));

  // R5: read data changes only on an accepted read
  p_dout_hold_r5: assert property (@(posedge rclk) disable iff (r_rst)
    !rd_fire |=> $stable(b_dout));

endmodule

bind dcfifo_flags dcf_checker #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .w_rst(w_rst), .r_rst(r_rst),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .wr_req(wr_req), .rd_req(rd_req), .rd_fire(rd_fire),
  .wbin(wbin), .rbin(rbin), .b_dout(b_dout)
);

// File: tb/dcfifo_flags_tb.sv
`timescale 1ns/1ps
module dcfifo_flags_tb;

  localparam int DW = 36;
  localparam int DEPTH = 64;

  logic          wclk = 0, rclk = 0, rst_n = 0;
  logic [1:0]    ofs_sel = 0;
  logic          a_cs_n = 1, a_wr_rd = 0, a_en = 0, a_mb = 0;
  logic          b_cs_n = 1, b_wr_rd = 1, b_en = 0, b_mb = 0;
  logic [DW-1:0] a_din = '0;
  logic [DW-1:0] b_dout;
  logic          a_oe, b_oe, full_n, afull_n, empty_n, aempty_n;

  int checks = 0;
  int errors = 0;

  always #2 wclk = ~wclk;   // 250 MHz write clock
  always #3 rclk = ~rclk;   // unrelated read clock

  dcfifo_flags u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ofs_sel(ofs_sel),
    .a_cs_n(a_cs_n), .a_wr_rd(a_wr_rd), .a_en(a_en), .a_mb(a_mb),
    .a_din(a_din), .a_oe(a_oe),
    .b_cs_n(b_cs_n), .b_wr_rd(b_wr_rd), .b_en(b_en), .b_mb(b_mb),
    .b_dout(b_dout), .b_oe(b_oe),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic a_idle();
    a_cs_n = 1; a_wr_rd = 0; a_en = 0; a_mb = 0;
  endtask

  task automatic b_idle();
    b_cs_n = 1; b_wr_rd = 1; b_en = 0; b_mb = 0;
  endtask

  task automatic settle();
    repeat (8) @(posedge rclk);
    repeat (8) @(posedge wclk);
  endtask

  task automatic write_word(input logic [DW-1:0] d);
    @(negedge wclk);
    a_cs_n = 0; a_wr_rd = 1; a_en = 1; a_mb = 0; a_din = d;
    @(negedge wclk);
    a_idle();
  endtask

  task automatic read_word(output logic [DW-1:0] d);
    @(negedge rclk);
    b_cs_n = 0; b_wr_rd = 0; b_en = 1; b_mb = 0;
    @(negedge rclk);
    b_idle();
    d = b_dout;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge wclk);
    rst_n = 0; ofs_sel = sel;
    repeat (6) @(posedge rclk);
    repeat (2) @(posedge wclk);
    #1;
    chk(full_n == 0,   "R1", "full_n in reset",   full_n, 0);
    chk(empty_n == 0,  "R1", "empty_n in reset",  empty_n, 0);
    chk(aempty_n == 0, "R1", "aempty_n in reset", aempty_n, 0);
    chk(afull_n == 1,  "R1", "afull_n in reset",  afull_n, 1);
    @(negedge wclk);
    rst_n = 1;
    @(posedge wclk); #1;
    chk(full_n == 0, "R2", "full_n after first edge", full_n, 0);
    @(posedge wclk); #1;
    chk(full_n == 1, "R2", "full_n after second edge", full_n, 1);
    settle();
    chk(empty_n == 0,  "R1", "empty_n after release",  empty_n, 0);
    chk(aempty_n == 0, "R1", "aempty_n after release", aempty_n, 0);
    chk(afull_n == 1,  "R1", "afull_n after release",  afull_n, 1);
  endtask

  function automatic logic [DW-1:0] pat(input int s, input int n);
    return DW'(36'h5A0000000 + 36'(s * 4096) + 36'(n * 7));
  endfunction

  initial begin
    logic [DW-1:0] got;
    logic [DW-1:0] held;

    // ---- Port decode and bus enables ----
    do_reset(2'b00);

    // R6: drive enables over all select/direction pairs (enable kept low)
    for (int c = 0; c < 4; c++) begin
      @(negedge wclk);
      a_cs_n = c[1]; a_wr_rd = c[0]; a_en = 0;
      b_cs_n = c[1]; b_wr_rd = c[0]; b_en = 0;
      #1;
      chk(a_oe == (c == 0), "R6", "a_oe", a_oe, (c == 0));
      chk(b_oe == (c == 0), "R6", "b_oe", b_oe, (c == 0));
    end
    a_idle(); b_idle();
    settle();

    // R4: only {cs_n,wr_rd,en,mb}=0110 stores a word
    for (int c = 0; c < 16; c++) begin
      @(negedge wclk);
      {a_cs_n, a_wr_rd, a_en, a_mb} = 4'(c);
      a_din = DW'(100 + c);
      @(negedge wclk);
      a_idle();
    end
    settle();
    chk(empty_n == 1, "R4", "one word stored", empty_n, 1);
    read_word(got);
    chk(got == DW'(106), "R4", "decoded write data", got, 106);
    settle();
    chk(empty_n == 0, "R4", "only one word stored", empty_n, 0);

    // R5: only {cs_n,wr_rd,en,mb}=0010 reads; b_dout holds otherwise
    write_word(DW'(200));
    write_word(DW'(201));
    settle();
    for (int c = 0; c < 16; c++) begin
      @(negedge rclk);
      {b_cs_n, b_wr_rd, b_en, b_mb} = 4'(c);
      @(negedge rclk);
      b_idle();
      chk(b_dout == ((c >= 2) ? DW'(200) : DW'(106)), "R5", "decoded read",
          b_dout, (c >= 2) ? 200 : 106);
    end
    read_word(got);
    chk(got == DW'(201), "R5", "second word", got, 201);
    settle();
    chk(empty_n == 0, "R5", "drained", empty_n, 0);

    // leave words behind so the next reset must discard them (R1)
    write_word(DW'(1)); write_word(DW'(2)); write_word(DW'(3));
    settle();

    // ---- Threshold sweep over every select value: R3, R7, R8, R9 ----
    for (int s = 3; s >= 0; s--) begin
      int t;
      t = 4 * (s + 1);   // R3: 00->4, 01->8, 10->12, 11->16
      do_reset(2'(s));
      for (int n = 1; n <= DEPTH; n++) begin
        write_word(pat(s, n));
        settle();
        chk(aempty_n == (n > t), "R8", "aempty_n fill", aempty_n, (n > t));
        chk(afull_n == (DEPTH - n > t), "R3", "afull_n fill threshold",
            afull_n, (DEPTH - n > t));
        chk(empty_n == 1, "R7", "empty_n fill", empty_n, 1);
        chk(full_n == (n < DEPTH), "R7", "full_n fill", full_n, (n < DEPTH));
      end
      // R9: write while full is dropped
      write_word(pat(s, 999));
      settle();
      for (int n = 1; n <= DEPTH; n++) begin
        read_word(got);
        chk(got == pat(s, n), "R9", "drain data after blocked write", got, pat(s, n));
        settle();
        chk(aempty_n == (DEPTH - n > t), "R8", "aempty_n drain",
            aempty_n, (DEPTH - n > t));
        chk(afull_n == (n > t), "R8", "afull_n drain", afull_n, (n > t));
        chk(full_n == 1, "R7", "full_n drain", full_n, 1);
        chk(empty_n == (n < DEPTH), "R7", "empty_n drain", empty_n, (n < DEPTH));
      end
      // R9: read while empty leaves b_dout and the pointer alone
      held = b_dout;
      read_word(got);
      chk(got == held, "R9", "b_dout on empty read", got, held);
      write_word(pat(s, 500));
      settle();
      read_word(got);
      chk(got == pat(s, 500), "R9", "next word after empty read", got, pat(s, 500));
      settle();
      chk(empty_n == 0, "R9", "empty after single word", empty_n, 0);
    end

    // ---- Concurrent streaming: R10 ----
    do_reset(2'b01);
    fork
      begin : writer
        int wi;
        wi = 0;
        while (wi < 300) begin
          @(negedge wclk);
          if (full_n) begin
            a_cs_n = 0; a_wr_rd = 1; a_en = 1; a_mb = 0;
            a_din = DW'(36'h900000000 + 36'(wi));
            wi++;
          end else begin
            a_idle();
          end
        end
        @(negedge wclk);
        a_idle();
      end
      begin : reader
        int rj;
        bit armed;
        rj = 0; armed = 0;
        while (rj < 300) begin
          @(negedge rclk);
          if (armed) begin
            chk(b_dout == DW'(36'h900000000 + 36'(rj)), "R10", "stream order",
                b_dout, 36'h900000000 + 36'(rj));
            rj++;
          end
          armed = (rj < 300) && empty_n;
          if (armed) begin
            b_cs_n = 0; b_wr_rd = 0; b_en = 1; b_mb = 0;
          end else begin
            b_idle();
          end
        end
        b_idle();
      end
    join
    settle();
    chk(empty_n == 0, "R10", "empty after stream", empty_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    errors++;
    $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule